// File: doc/BRIEF.md
# Translation Table Bulk Update Engine

This block owns a small table of 64-bit translation entries and services commands that change or read it. There are four commands: write one entry, read one entry, fill a run of consecutive entries with a single value, and load a run of consecutive entries from a list held in memory. Every command carries a 64-bit table identifier, an IO address, an argument (the value, or the list address) and a count. The block answers each command with a one-cycle completion pulse and a status bit.

An IO address selects an entry as follows. Its bits below the page size are cleared, the configured bus offset is subtracted, and the result is shifted right by the page shift. Multi-entry commands step the IO address forward one page at a time. They stop at the first entry that falls outside the table, and entries written before that point keep their new values. The list command fetches list words over a simple request/response read port, one request at a time.

Top module: `tce_bulk_engine`

## Requirements
- R1: A command whose identifier has any of bits 63..32 set, or whose low 32 bits differ from the configured identifier, completes one cycle after acceptance with status 1 and leaves the table unchanged.
- R2: Entry index = ((IO address with its low PAGE_SHIFT bits cleared) − BUS_OFFSET) >> PAGE_SHIFT, computed modulo 2^64. An index at or above ENTRIES, including one from an address below the bus offset, gives status 1.
- R3: Put (op 0) stores the argument in the selected entry and completes one cycle after acceptance with status 0. The IO address bits below the page size do not affect which entry is chosen.
- R4: Get (op 1) completes one cycle after acceptance with status 0 and the stored entry on rd_data. rd_data changes only on a successful get. Every entry reads as zero after reset.
- R5: Fill (op 2) with a count of 0 or above ENTRIES completes one cycle after acceptance with status 1. Otherwise it writes one entry per cycle, for count cycles, and pulses done with status 0 in the cycle after the last write.
- R6: Fill stops at its first out-of-range entry and completes in the cycle after that entry with status 1. Entries written earlier in the same command keep the fill value.
- R7: Indirect (op 3) with a count of 0, a count above LIST_MAX (512), or a list address with any of bits 11..0 set completes one cycle after acceptance with status 1, without any memory request.
- R8: For each list element i, indirect raises mem_req for exactly one cycle with mem_addr = list address + 8·i, waits for mem_rsp_valid, and then writes the entry. Response byte lane k (bits 8k+7..8k) holds the byte at mem_addr+k. The word is big-endian, so lane 0 becomes entry bits 63..56. The next request follows in the cycle after the write.
- R9: Indirect stops at its first out-of-range entry and completes with status 1 in the cycle after that element's response. Entries written earlier keep their values.
- R10: cmd_ready is 1 exactly when the engine is idle, and a command is taken only when cmd_valid and cmd_ready are both 1. A command held on cmd_valid while the engine is busy has no effect. done is never 1 while cmd_ready is 0. Status is 0 for success and 1 for parameter error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 put, 1 get, 2 fill, 3 indirect |
| cmd_table | input | 64 | Table identifier |
| cmd_ioaddr | input | 64 | IO address of first entry |
| cmd_arg | input | 64 | Entry value (put, fill) or list address (indirect) |
| cmd_count | input | CNT_W | Entry count (fill, indirect) |
| mem_req | output | 1 | List word read request |
| mem_addr | output | 64 | Byte address of requested list word |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Read response, lane k = byte at mem_addr+k |
| done | output | 1 | Completion pulse |
| status | output | 1 | Completion status, valid with done |
| rd_data | output | 64 | Entry value returned by get |

## Verification
Some properties are checked by the assertions on every cycle. Rejection of a bad identifier, a zero fill count, or an oversized or misaligned list comes back as an error in the very next cycle. A list request never lasts more than one cycle, is always word-aligned, and only appears while busy. Completion never occurs while busy. Other behaviour can only be shown by the bench's scenarios, because it depends on table contents and on history: index arithmetic across the bus offset and table end, partial writes left behind by a stopped fill or list walk, the byte order of loaded words, response latency, and commands held during a busy walk having no effect.

// File: rtl/tce_bulk_engine.sv
module tce_bulk_engine #(
  parameter logic [31:0] TABLE_ID   = 32'h8000_0002,
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_4000_0000,
  parameter int          PAGE_SHIFT = 12,
  parameter int          ENTRIES    = 32,
  parameter int          LIST_MAX   = 512,
  parameter int          LIST_SHIFT = 12,
  parameter int          CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [63:0]       cmd_table,
  input  logic [63:0]       cmd_ioaddr,
  input  logic [63:0]       cmd_arg,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic              status,
  output logic [63:0]       rd_data
);
  localparam int          IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [63:0] PAGE      = 64'd1 << PAGE_SHIFT;
  localparam logic [63:0] PAGE_MASK = ~(PAGE - 64'd1);
  localparam logic [CNT_W-1:0] FILL_LIM = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] LIST_LIM = CNT_W'(LIST_MAX);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_REQ, S_WAIT} state_t;

  state_t            state;
  logic [63:0]       cur_addr, arg_q;
  logic [CNT_W-1:0]  left, step;
  logic [63:0]       tbl [ENTRIES];
  logic [63:0]       walk_idx, be_word;
  logic              walk_ok, id_ok;

  assign cmd_ready = (state == S_IDLE);
  assign mem_req   = (state == S_REQ);
  assign mem_addr  = arg_q + 64'({step, 3'b000});
  assign id_ok     = (cmd_table[63:32] == 32'd0) && (cmd_table[31:0] == TABLE_ID);
  assign walk_idx  = (((state == S_IDLE) ? cmd_ioaddr : cur_addr) & PAGE_MASK) - BUS_OFFSET >> PAGE_SHIFT;
  assign walk_ok   = walk_idx < 64'(ENTRIES);

  for (genvar k = 0; k < 8; k++) begin : g_swap
    assign be_word[63-8*k -: 8] = mem_rsp_data[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      status   <= 1'b0;
      rd_data  <= '0;
      cur_addr <= '0;
      arg_q    <= '0;
      left     <= '0;
      step     <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          cur_addr <= cmd_ioaddr & PAGE_MASK;
          arg_q    <= cmd_arg;
          left     <= cmd_count;
          step     <= '0;
          if (!id_ok) begin
            done <= 1'b1; status <= 1'b1;
          end else begin
            case (cmd_op)
              2'd0: begin
                done <= 1'b1; status <= !walk_ok;
                if (walk_ok) tbl[walk_idx[IDX_W-1:0]] <= cmd_arg;
              end
              2'd1: begin
                done <= 1'b1; status <= !walk_ok;
                if (walk_ok) rd_data <= tbl[walk_idx[IDX_W-1:0]];
              end
              2'd2: begin
                if (cmd_count == '0 || cmd_count > FILL_LIM) begin
                  done <= 1'b1; status <= 1'b1;
                end else state <= S_FILL;
              end
              default: begin
                if (cmd_count == '0 || cmd_count > LIST_LIM || cmd_arg[LIST_SHIFT-1:0] != '0) begin
                  done <= 1'b1; status <= 1'b1;
                end else state <= S_REQ;
              end
            endcase
          end
        end
        S_FILL: begin
          if (!walk_ok) begin
            done <= 1'b1; status <= 1'b1; state <= S_IDLE;
          end else begin
            tbl[walk_idx[IDX_W-1:0]] <= arg_q;
            cur_addr <= cur_addr + PAGE;
            left     <= left - ONE;
            if (left == ONE) begin
              done <= 1'b1; status <= 1'b0; state <= S_IDLE;
            end
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!walk_ok) begin
            done <= 1'b1; status <= 1'b1; state <= S_IDLE;
          end else begin
            tbl[walk_idx[IDX_W-1:0]] <= be_word;
            cur_addr <= cur_addr + PAGE;
            left     <= left - ONE;
            step     <= step + ONE;
            if (left == ONE) begin
              done <= 1'b1; status <= 1'b0; state <= S_IDLE;
            end else state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tce_bulk_engine_chk.sv
module tce_bulk_engine_chk #(
  parameter logic [31:0] TABLE_ID   = 32'h8000_0002,
  parameter int          LIST_MAX   = 512,
  parameter int          LIST_SHIFT = 12,
  parameter int          CNT_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [63:0]      cmd_table,
  input logic [63:0]      cmd_arg,
  input logic [CNT_W-1:0] cmd_count,
  input logic             mem_req,
  input logic [63:0]      mem_addr,
  input logic             done,
  input logic             status
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  assert_bad_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && (cmd_table[63:32] != 32'd0 || cmd_table[31:0] != TABLE_ID) |=> done && status);

  assert_fill_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 2'd2 && cmd_count == '0 |=> done && status);

  assert_list_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 2'd3 && (cmd_count > CNT_W'(LIST_MAX) || cmd_arg[LIST_SHIFT-1:0] != '0)
    |=> done && status && !mem_req);

  assert_single_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_req_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'b000 && !cmd_ready);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

bind tce_bulk_engine tce_bulk_engine_chk #(
  .TABLE_ID(TABLE_ID), .LIST_MAX(LIST_MAX), .LIST_SHIFT(LIST_SHIFT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_table(cmd_table), .cmd_arg(cmd_arg), .cmd_count(cmd_count),
  .mem_req(mem_req), .mem_addr(mem_addr), .done(done), .status(status)
);

// File: tb/sim_tce_bulk_engine.sv
module sim_tce_bulk_engine;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TID        = 32'h8000_0002;
  localparam logic [63:0] BOFF       = 64'h0000_0000_4000_0000;
  localparam int          SHIFT      = 12;
  localparam int          NENT       = 32;
  localparam logic [63:0] PG         = 64'd1 << SHIFT;
  localparam logic [63:0] GOOD_ID    = {32'd0, TID};

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [63:0] cmd_table = 0, cmd_ioaddr = 0, cmd_arg = 0;
  logic [15:0] cmd_count = 0;
  logic mem_req, mem_rsp_valid = 0;
  logic [63:0] mem_addr, mem_rsp_data = 0;
  logic done, status;
  logic [63:0] rd_data;

  int checks = 0, errors = 0, lat = 1, pend = 0;
  logic [63:0] paddr;
  string cur_req = "R10";
  logic [63:0] model_tbl [NENT];
  logic [63:0] model_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tce_bulk_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_table(cmd_table), .cmd_ioaddr(cmd_ioaddr), .cmd_arg(cmd_arg),
    .cmd_count(cmd_count), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .status(status), .rd_data(rd_data));

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return 8'(a * 13 + (a >> 8) + 8'h5A);
  endfunction

  function automatic logic [63:0] be_val(input logic [63:0] a);
    logic [63:0] v = 0;
    for (int k = 0; k < 8; k++) v = {v[55:0], mbyte(a + 64'(k))};
    return v;
  endfunction

  function automatic logic [63:0] ent(input int i);
    return BOFF + 64'(i) * PG;
  endfunction

  function automatic logic [63:0] m_idx(input logic [63:0] a);
    return (a >> SHIFT) - (BOFF >> SHIFT);
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1;
        for (int k = 0; k < 8; k++) mem_rsp_data[8*k +: 8] = mbyte(paddr + 64'(k));
      end
    end else if (mem_req) begin
      pend = lat;
      paddr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic step(input bit er, input bit ed, input bit es, input bit eq, input logic [63:0] ea);
    @(negedge clk);
    chk(cmd_ready === er, "ready", 64'(cmd_ready), 64'(er));
    chk(done === ed, "done", 64'(done), 64'(ed));
    if (ed) chk(status === es, "status", 64'(status), 64'(es));
    chk(mem_req === eq, "mem_req", 64'(mem_req), 64'(eq));
    if (eq) chk(mem_addr === ea, "mem_addr", mem_addr, ea);
    chk(rd_data === model_rd, "rd_data", rd_data, model_rd);
  endtask

  task automatic after_first(input bit poke);
    if (poke) begin
      cmd_op = 2'd0; cmd_table = GOOD_ID; cmd_ioaddr = ent(0); cmd_arg = 64'hDEAD_BEEF;
    end else cmd_valid = 0;
  endtask

  task automatic do_cmd(input int op, input logic [63:0] tid, input logic [63:0] io,
                        input logic [63:0] arg, input int cnt, input bit poke);
    logic [63:0] idx;
    bit bad = 0, first = 1;
    cmd_op = op[1:0]; cmd_table = tid; cmd_ioaddr = io; cmd_arg = arg;
    cmd_count = 16'(cnt); cmd_valid = 1;
    idx = m_idx(io);
    if (tid !== GOOD_ID) begin
      step(1, 1, 1, 0, 0); cmd_valid = 0;
    end else if (op == 0 || op == 1) begin
      if (idx < NENT) begin
        if (op == 0) model_tbl[idx] = arg; else model_rd = model_tbl[idx];
      end
      step(1, 1, !(idx < NENT), 0, 0); cmd_valid = 0;
    end else if (op == 2 && (cnt == 0 || cnt > NENT)) begin
      step(1, 1, 1, 0, 0); cmd_valid = 0;
    end else if (op == 3 && (cnt == 0 || cnt > 512 || arg[11:0] != 0)) begin
      step(1, 1, 1, 0, 0); cmd_valid = 0;
    end else begin
      for (int j = 0; j < cnt; j++) begin
        logic [63:0] e = idx + 64'(j);
        if (op == 3) begin
          step(0, 0, 0, 1, arg + 64'(8 * j));
          if (first) begin first = 0; after_first(poke); end
          for (int w = 0; w < lat; w++) step(0, 0, 0, 0, 0);
        end else begin
          step(0, 0, 0, 0, 0);
          if (first) begin first = 0; after_first(poke); end
        end
        if (!(e < NENT)) begin bad = 1; break; end
        model_tbl[e] = (op == 3) ? be_val(arg + 64'(8 * j)) : arg;
      end
      cmd_valid = 0;
      step(1, 1, bad, 0, 0);
    end
    step(1, 0, 0, 0, 0);
  endtask

  task automatic get_chk(input int i);
    do_cmd(1, GOOD_ID, ent(i), 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL %s watchdog: got %h expected %h", cur_req, 64'(0), 64'(1));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NENT; i++) model_tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R10"; step(1, 0, 0, 0, 0);
    cur_req = "R4";  get_chk(3); get_chk(31);
    cur_req = "R3";  do_cmd(0, GOOD_ID, ent(3) + 64'h7FF, 64'h1122_3344_5566_7788, 0, 0);
    cur_req = "R4";  get_chk(3);
    cur_req = "R3";  do_cmd(0, GOOD_ID, ent(3) + PG - 1, 64'hAAAA_0000_0000_0001, 0, 0);
    cur_req = "R4";  do_cmd(1, GOOD_ID, ent(3) + 64'h10, 0, 0, 0);
    cur_req = "R1";  do_cmd(0, {32'd1, TID}, ent(5), 64'h55, 0, 0);
    do_cmd(0, {32'd0, TID ^ 32'h1}, ent(5), 64'h66, 0, 0);
    do_cmd(2, {32'h8000_0000, TID}, ent(5), 64'h77, 2, 0);
    get_chk(5);
    cur_req = "R2";  do_cmd(0, GOOD_ID, BOFF - PG, 64'h99, 0, 0);
    do_cmd(0, GOOD_ID, ent(NENT), 64'h99, 0, 0);
    do_cmd(1, GOOD_ID, ent(NENT) + 64'h123, 0, 0, 0);
    do_cmd(0, GOOD_ID, ent(NENT - 1), 64'hF1F1, 0, 0);
    get_chk(NENT - 1);
    cur_req = "R5";  do_cmd(2, GOOD_ID, ent(8), 64'hBAD, 0, 0);
    do_cmd(2, GOOD_ID, ent(8), 64'hBAD, NENT + 1, 0);
    do_cmd(2, GOOD_ID, ent(8) + 64'h44, 64'hC0DE_0001, 4, 0);
    get_chk(7); get_chk(8); get_chk(11); get_chk(12);
    do_cmd(2, GOOD_ID, ent(0), 64'h0F0F, NENT, 0);
    get_chk(0); get_chk(NENT - 1);
    cur_req = "R6";  do_cmd(2, GOOD_ID, ent(NENT - 2), 64'hE6E6, 5, 0);
    get_chk(NENT - 3); get_chk(NENT - 2); get_chk(NENT - 1);
    do_cmd(2, GOOD_ID, BOFF - PG, 64'h1234, 3, 0);
    get_chk(0);
    cur_req = "R10"; do_cmd(2, GOOD_ID, ent(16), 64'hF00D, 3, 1);
    get_chk(0); get_chk(16); get_chk(18);
    cur_req = "R7";  do_cmd(3, GOOD_ID, ent(12), 64'h1_0000, 513, 0);
    do_cmd(3, GOOD_ID, ent(12), 64'h1_0008, 2, 0);
    do_cmd(3, GOOD_ID, ent(12), 64'h1_0000, 0, 0);
    get_chk(12);
    cur_req = "R8";  lat = 1; do_cmd(3, GOOD_ID, ent(12), 64'h2_3000, 3, 0);
    get_chk(12); get_chk(13); get_chk(14);
    lat = 3; do_cmd(3, GOOD_ID, ent(20) + 64'h9, 64'h7_7000, 4, 0);
    get_chk(20); get_chk(23); get_chk(24);
    lat = 2; do_cmd(3, GOOD_ID, ent(0), 64'h5000, 512, 0);
    get_chk(0); get_chk(NENT - 1);
    cur_req = "R9";  lat = 1; do_cmd(3, GOOD_ID, ent(NENT - 2), 64'h9_1000, 4, 0);
    get_chk(NENT - 2); get_chk(NENT - 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule